// File: doc/BRIEF.md
# Distributed DRAM Refresh Generator

This block schedules RAS-only refresh for a dynamic memory array, paced by a horizontal line timebase. At every line start it opens a fixed budget of refresh slots and raises a request toward the display DMA arbiter. Each slot the arbiter grants produces a one-cycle refresh strobe, together with a row address taken from an internal row counter. The counter then steps by one and wraps at the top of its range. While the strobe is high, memory must neither drive nor sample the data bus.

Two scheduling modes are offered. In distributed mode the slots are spread over every line. Slots that display DMA has displaced and that are still unserved when the next line begins are dropped rather than carried forward, and a wrapping drop counter records them. In burst mode the block requests every row back to back, once per fixed group of lines. Memory stays unavailable until the burst has completed, and line starts that arrive during the burst neither end it nor drop anything.

The only reset is the block's own power-on reset. The system reset is deliberately not wired to it, so refresh carries on while the rest of the chip is held in reset. The row counter width is a parameter: 7 bits covers 128 rows, 8 bits covers 256 rows and 9 bits covers 512 rows. At an equal slot rate, each added bit doubles the time before a given row comes round again.

Top module: `refresh_gen`

## Requirements
- R1: After power-on reset `refReq` and `refStrobe` are 0, `rowAddr` is 0 and `dropCount` is 0.
- R2: In distributed mode (`burstMode` = 0), each `lineStart` pulse loads a budget of SLOTS_PER_LINE slots (default 9). `refReq` is high from the cycle after the pulse until that many slots have been granted, and is low after that.
- R3: A cycle in which `refReq` and `grant` are both high and `lineStart` is low issues a slot. In the next cycle `refStrobe` is high for exactly one cycle and `rowAddr` shows the row counter's value, and the counter then advances by one. `rowAddr` holds its value between strobes.
- R4: The row counter is ROW_BITS wide (default 8). After row 2^ROW_BITS-1 the next strobe addresses row 0.
- R5: A grant has no effect when `refReq` is low, and also in a cycle in which `lineStart` is high: no strobe follows and `rowAddr` is unchanged.
- R6: While `grant` stays low, `refReq` stays high and no strobe is issued.
- R7: In distributed mode, slots still pending at a `lineStart` are dropped. `dropCount` (DROP_BITS wide, wrapping) grows by the number dropped, and the new line receives a fresh budget of exactly SLOTS_PER_LINE. `dropCount` changes only in the cycle after a `lineStart`.
- R8: In burst mode, a `lineStart` whose index since reset is a multiple of BURST_LINES (default 64, the first line having index 0) starts a burst of 2^ROW_BITS slots. `refReq` then stays high until every one of those slots has been granted, and line starts during the burst neither end it nor change `dropCount`.
- R9: In burst mode, a `lineStart` at any other index, with no burst running, requests no slots and drops nothing.
- R10: With a single granted slot per line in distributed mode, every row is refreshed within 2^ROW_BITS lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low; the only reset of the block |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| grant | input | 1 | Slot grant from the DMA arbiter; low means the slot is stalled |
| burstMode | input | 1 | 1 selects burst mode, 0 selects distributed mode; sampled at line start |
| refReq | output | 1 | Refresh slots are pending |
| refStrobe | output | 1 | Refresh cycle in progress; memory keeps off the data bus |
| rowAddr | output | ROW_BITS | Row being refreshed |
| dropCount | output | DROP_BITS | Wrapping count of slots dropped at line boundaries |

## Verification
The bench concentrates on the boundaries of the slot budget.

A grant that arrives in the same cycle as a line start must be ignored. A design that honours it would strobe a row that then belongs to neither line.

Leftover slots must be dropped and not carried forward. A carrying design would show a tenth strobe on the next line, and a `dropCount` other than six after three of nine slots.

The row counter must wrap from 255 to 0. A mis-sized counter would skip row 0 or run past 255, and the long run at one slot per line would then leave a row unrefreshed inside the retention window.

In burst mode the request must stay high across the line starts that occur mid-burst and must return only at line 64. A design that restarts or drops on every line would show up as an early fall of `refReq` or a non-zero `dropCount`.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // strobes passed from slot control to the row datapath
  typedef struct packed {
    logic issue;   // a granted slot is fired this cycle
  } refCtlT;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int ROW_BITS       = 8,
  parameter int SLOTS_PER_LINE = 9,
  parameter int BURST_LINES    = 64,
  parameter int DROP_BITS      = 8
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 lineStart,
  input  logic                 grant,
  input  logic                 burstMode,
  output refCtlT               ctl,
  output logic                 refReq,
  output logic [DROP_BITS-1:0] dropCount
);
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int PEND_MAX = (ROWS > SLOTS_PER_LINE) ? ROWS : SLOTS_PER_LINE;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);
  localparam int LINE_W   = (BURST_LINES > 1) ? $clog2(BURST_LINES) : 1;

  logic [PEND_W-1:0] pending;
  logic [LINE_W-1:0] lineCnt;
  logic              burstActive;

  assign refReq    = (pending != '0);
  assign ctl.issue = refReq & grant & ~lineStart;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pending     <= '0;
      lineCnt     <= '0;
      burstActive <= 1'b0;
      dropCount   <= '0;
    end else if (lineStart) begin
      lineCnt <= (lineCnt == LINE_W'(BURST_LINES - 1)) ? '0 : lineCnt + 1'b1;
      if (!burstActive) begin
        dropCount <= dropCount + DROP_BITS'(pending);
        if (!burstMode) begin
          pending <= PEND_W'(SLOTS_PER_LINE);
        end else if (lineCnt == '0) begin
          pending     <= PEND_W'(ROWS);
          burstActive <= 1'b1;
        end else begin
          pending <= '0;
        end
      end
    end else if (ctl.issue) begin
      pending <= pending - 1'b1;
      if (pending == PEND_W'(1)) burstActive <= 1'b0;
    end
  end

  // R7: drop tally moves only on a line boundary
  p_drop_at_line_r7: assert property (@(posedge clk) disable iff (!porN)
    !lineStart |=> $stable(dropCount));

  // R8: a running burst always keeps its request up
  p_burst_req_r8: assert property (@(posedge clk) disable iff (!porN)
    burstActive |-> refReq);

  // R8: line starts inside a burst drop nothing
  p_burst_no_drop_r8: assert property (@(posedge clk) disable iff (!porN)
    (lineStart && burstActive) |=> $stable(dropCount));
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int ROW_BITS = 8
) (
  input  logic                clk,
  input  logic                porN,
  input  refCtlT              ctl,
  output logic                refStrobe,
  output logic [ROW_BITS-1:0] rowAddr
);
  logic [ROW_BITS-1:0] rowCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rowCnt    <= '0;
      rowAddr   <= '0;
      refStrobe <= 1'b0;
    end else begin
      refStrobe <= ctl.issue;
      if (ctl.issue) begin
        rowAddr <= rowCnt;
        rowCnt  <= rowCnt + 1'b1;   // natural wrap at the top row
      end
    end
  end

  // R4: back-to-back strobes address successive rows, wrapping
  p_row_step_r4: assert property (@(posedge clk) disable iff (!porN)
    (refStrobe && $past(refStrobe)) |-> rowAddr == ROW_BITS'($past(rowAddr) + 1'b1));

  // R3: address is held between strobes
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!porN)
    !refStrobe |-> $stable(rowAddr));
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen
  import refresh_pkg::*;
#(
  parameter int ROW_BITS       = 8,
  parameter int SLOTS_PER_LINE = 9,
  parameter int BURST_LINES    = 64,
  parameter int DROP_BITS      = 8
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 lineStart,
  input  logic                 grant,
  input  logic                 burstMode,
  output logic                 refReq,
  output logic                 refStrobe,
  output logic [ROW_BITS-1:0]  rowAddr,
  output logic [DROP_BITS-1:0] dropCount
);
  refCtlT ctl;

  refresh_ctrl #(
    .ROW_BITS(ROW_BITS), .SLOTS_PER_LINE(SLOTS_PER_LINE),
    .BURST_LINES(BURST_LINES), .DROP_BITS(DROP_BITS)
  ) u_ctrl (
    .clk(clk), .porN(porN), .lineStart(lineStart), .grant(grant),
    .burstMode(burstMode), .ctl(ctl), .refReq(refReq), .dropCount(dropCount)
  );

  refresh_dp #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .porN(porN), .ctl(ctl), .refStrobe(refStrobe), .rowAddr(rowAddr)
  );

  // R3: every strobe follows a grant
  p_strobe_after_grant_r3: assert property (@(posedge clk) disable iff (!porN)
    refStrobe |-> $past(grant));

  // R5: no strobe from a grant without request or on a line-start cycle
  p_no_idle_strobe_r5: assert property (@(posedge clk) disable iff (!porN)
    refStrobe |-> ($past(refReq) && !$past(lineStart)));
endmodule

// File: tb/tb_refresh_gen.sv
module tb_refresh_gen;
  localparam int ROW_BITS = 8;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int SLOTS    = 9;
  localparam int BLINES   = 64;
  localparam int DBITS    = 8;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic lineStart = 1'b0;
  logic grant = 1'b0;
  logic burstMode = 1'b0;
  logic refReq, refStrobe;
  logic [ROW_BITS-1:0] rowAddr;
  logic [DBITS-1:0] dropCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  refresh_gen #(.ROW_BITS(ROW_BITS), .SLOTS_PER_LINE(SLOTS),
                .BURST_LINES(BLINES), .DROP_BITS(DBITS)) dut (
    .clk(clk), .porN(porN), .lineStart(lineStart), .grant(grant),
    .burstMode(burstMode), .refReq(refReq), .refStrobe(refStrobe),
    .rowAddr(rowAddr), .dropCount(dropCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    porN = 1'b0; lineStart = 1'b0; grant = 1'b0; burstMode = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
  endtask

  // one-cycle line pulse; returns at the negedge after the edge
  task automatic pulseLine();
    lineStart = 1'b1;
    @(posedge clk); @(negedge clk);
    lineStart = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 refReq", refReq, 0);
    chk("R1 refStrobe", refStrobe, 0);
    chk("R1 rowAddr", rowAddr, 0);
    chk("R1 dropCount", dropCount, 0);
  endtask

  task automatic t_distributed();
    doReset();
    pulseLine();
    chk("R2 request after line", refReq, 1);
    grant = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R3 strobe", refStrobe, 1);
      chk("R3 row", rowAddr, i);
    end
    chk("R2 request ends after budget", refReq, 0);
    @(posedge clk); @(negedge clk);
    grant = 1'b0;
    chk("R5 no strobe without request", refStrobe, 0);
    chk("R5 row unchanged", rowAddr, SLOTS - 1);
  endtask

  task automatic t_stall();
    doReset();
    pulseLine();
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R6 request held", refReq, 1);
      chk("R6 no strobe", refStrobe, 0);
    end
  endtask

  task automatic t_drop();
    int n;
    doReset();
    pulseLine();
    grant = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk("R3 row before drop", rowAddr, 2);
    // grant stays high across the line pulse
    pulseLine();
    chk("R5 grant on line cycle ignored", refStrobe, 0);
    chk("R7 six slots dropped", dropCount, SLOTS - 3);
    chk("R7 fresh request", refReq, 1);
    n = 0;
    while (refReq && n < 20) begin
      @(posedge clk); @(negedge clk);
      chk("R7 strobe row", rowAddr, 3 + n);
      n++;
    end
    grant = 1'b0;
    chk("R7 budget not carried over", n, SLOTS);
    pulseLine();
    chk("R7 nothing dropped when done", dropCount, SLOTS - 3);
  endtask

  task automatic t_wrap();
    int n = 0;
    doReset();
    while (n < ROWS + 4) begin
      pulseLine();
      grant = 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
        @(posedge clk); @(negedge clk);
        if (n == ROWS - 1 || n == ROWS)
          chk("R4 wrap row", rowAddr, n % ROWS);
        n++;
      end
      grant = 1'b0;
    end
  endtask

  task automatic t_retention();
    bit seen [ROWS];
    int missing = 0;
    doReset();
    for (int r = 0; r < ROWS; r++) seen[r] = 1'b0;
    for (int l = 0; l < ROWS; l++) begin
      pulseLine();
      grant = 1'b1;
      @(posedge clk); @(negedge clk);
      grant = 1'b0;
      if (refStrobe) seen[rowAddr] = 1'b1;
      repeat (3) @(negedge clk);
    end
    for (int r = 0; r < ROWS; r++) if (!seen[r]) missing++;
    chk("R10 rows missed in window", missing, 0);
    chk("R7 drop tally wraps", dropCount, ((ROWS - 1) * (SLOTS - 1)) % (1 << DBITS));
  endtask

  task automatic t_burst();
    int n = 0;
    int cyc = 0;
    int lines = 0;
    bit ls;
    int reqDrop = 0;
    doReset();
    burstMode = 1'b1;
    pulseLine();
    lines = 1;
    chk("R8 burst request", refReq, 1);
    grant = 1'b1;
    while (n < ROWS && cyc < 2 * ROWS) begin
      ls = (cyc % 40 == 39);
      lineStart = ls;
      if (ls) lines++;
      @(posedge clk); @(negedge clk);
      lineStart = 1'b0;
      if (ls) begin
        chk("R8 request survives line", refReq, 1);
      end else begin
        if (!refStrobe || rowAddr != ROW_BITS'(n)) reqDrop++;
        n++;
      end
      cyc++;
    end
    grant = 1'b0;
    chk("R8 burst rows in order", reqDrop, 0);
    chk("R8 burst ends", refReq, 0);
    chk("R8 no drop in burst", dropCount, 0);
    pulseLine();
    lines++;
    chk("R9 no request off-index", refReq, 0);
    while (lines < BLINES) begin
      pulseLine();
      lines++;
    end
    chk("R9 no drop off-index", dropCount, 0);
    pulseLine();
    chk("R8 burst at next group", refReq, 1);
  endtask

  initial begin
    t_reset();
    t_distributed();
    t_stall();
    t_drop();
    t_wrap();
    t_retention();
    t_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule